// File: doc/BRIEF.md
# Multi-channel packet transmit FIFO

This block sits on the command path of a serial display link. Software, or a DMA engine, writes 32-bit words into it. Each write goes to one of several virtual channels and names one of three kinds: a long-packet header, a long-packet payload word, or a complete short packet. All channels share one word store. Each channel owns a region of that store, given by a base and a size. The block keeps each channel's words in arrival order and sends them out as a byte stream with a valid/ready handshake. Every byte carries a tag that says whether it belongs to a short or a long packet, and the number of the channel it came from.

The block uses the word count in each long header to work out how many payload bytes are valid. The last payload word is cut down to the exact byte count, and payload writes beyond the count are dropped. Each channel raises a request line while its packet still needs payload and its region has room for a full burst. A channel only starts sending once one of its start conditions fires. Enabling a channel takes effect only while its region is empty. Disabling a channel first flushes whatever the region still holds.

Top module: `dsl_cmd_txfifo`

## Requirements
- R1: After reset, `out_valid`, every bit of `dma_req` and every bit of `ch_active` are 0.
- R2: A channel whose `ch_active` bit is 0 latches its region base and size from the config inputs. While `ch_en` is high it sets `ch_active` on the next clock edge. Writes to a channel are accepted only while both its `ch_en` and `ch_active` bits are 1.
- R3: The write kind is encoded as 0 = header, 1 = payload, 2 = short packet. A header stores its whole 32-bit word, and its bits [23:8] give the payload word count in bytes. A header with count 0 forms a complete packet of 4 bytes and needs no payload write.
- R4: Each payload word stores min(4, remaining count) valid bytes. The last word of a packet sends only those bytes and drops the rest.
- R5: Payload writes that arrive after the word count is used up are dropped, and no bytes reach the output for them.
- R6: A short-packet write produces 4 output bytes with `out_short` = 1. Header and payload bytes leave with `out_short` = 0.
- R7: Within a channel, words leave in write order. The bytes of each word leave least significant first.
- R8: A channel starts sending once a packet in its region is complete. Before that, with none of the other start conditions met, `out_valid` stays 0.
- R9: A channel starts sending when its region is full. A write to a full region is dropped.
- R10: A channel starts sending when payload is still expected but its free space is less than the burst size of `thr_sel`+1 words.
- R11: When `ch_en` falls, the channel sends everything left in its region. `ch_active` stays 1 until the region is empty and then falls.
- R12: `dma_req` for a channel is 1 exactly when the channel is enabled and active, payload is still expected, and free space is at least `thr_sel`+1 words.
- R13: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_short` and `out_ch` hold their values, and `out_valid` stays 1.
- R14: `out_ch` gives the source channel of each byte. At each word boundary the lowest-numbered channel that is sending wins the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_en | input | NCH | Enable per channel |
| cfg_base | input | NCH*AW | Region base per channel, packed |
| cfg_size | input | NCH*(AW+1) | Region size in words per channel, packed |
| thr_sel | input | 3 | Burst size minus one, in words |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | CHW | Target channel of the write |
| wr_kind | input | 2 | 0 header, 1 payload, 2 short packet |
| wr_data | input | 32 | Write data |
| ch_active | output | NCH | Channel active per channel |
| dma_req | output | NCH | Payload request per channel |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Link side accepts the byte |
| out_data | output | 8 | Output byte |
| out_short | output | 1 | Byte belongs to a short packet |
| out_ch | output | CHW | Source channel of the byte |

## Verification
The bench targets the trimmed last word. A design that ignores the word count would send two stale bytes, and one that sent surplus payload writes would leave extra bytes in the stream. It checks that each start condition fires and that no start happens too early: a region that is full, or too small for another burst, must begin draining, while a half-written packet must stay silent. It also covers the flush on disable, where a design that dropped `ch_active` too early would lose data, as well as holding the output under backpressure and arbitration between channels at word boundaries.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [1:0] {
        WK_HDR = 2'd0,
        WK_PAY = 2'd1,
        WK_SHT = 2'd2
    } wr_kind_e;

    typedef struct packed {
        logic [31:0] data;
        logic        is_short;
        logic [2:0]  nb;
    } txf_entry_t;
endpackage

// File: rtl/txf_chan.sv
module txf_chan #(
    parameter int AW  = 4,
    parameter int WCW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW:0]   cfg_size,
    input  logic [3:0]    thr_words,
    input  logic          wr_hdr,
    input  logic          wr_pay,
    input  logic          wr_sht,
    input  logic [31:0]   wr_data,
    input  logic          pop,
    output logic          push,
    output logic [AW-1:0] push_addr,
    output logic [2:0]    push_nb,
    output logic [AW-1:0] rd_addr,
    output logic          has_data,
    output logic          active,
    output logic          dma_req
);
    typedef struct packed {
        logic [AW-1:0]  base;
        logic [AW:0]    size;
        logic [AW:0]    cnt;
        logic [AW-1:0]  wr_off;
        logic [AW-1:0]  rd_off;
        logic [WCW-1:0] rem;
        logic           pend;
        logic           send;
        logic           active;
    } chan_s;

    chan_s s_q, s_d;
    logic [AW:0] free_w, thr_w;
    logic room, take_hdr, take_pay, take_sht, trig;

    always_comb begin
        s_d      = s_q;
        free_w   = s_q.size - s_q.cnt;
        thr_w    = (AW+1)'(thr_words);
        room     = s_q.cnt < s_q.size;
        take_hdr = wr_hdr && s_q.active && en && room;
        take_pay = wr_pay && s_q.active && en && room && (s_q.rem != '0);
        take_sht = wr_sht && s_q.active && en && room;
        push     = take_hdr || take_pay || take_sht;
        push_nb  = (take_pay && s_q.rem < WCW'(4)) ? {1'b0, s_q.rem[1:0]} : 3'd4;
        trig     = s_q.pend || (s_q.cnt == s_q.size) ||
                   ((s_q.rem != '0) && (free_w < thr_w)) || !en;

        if (!s_q.active) begin
            s_d.base = cfg_base;
            s_d.size = cfg_size;
            if (en) begin
                s_d.active = 1'b1;
                s_d.wr_off = '0;
                s_d.rd_off = '0;
                s_d.rem    = '0;
                s_d.pend   = 1'b0;
            end
        end else if (!en && s_q.cnt == '0) begin
            s_d.active = 1'b0;
        end

        if (take_hdr) begin
            s_d.rem = wr_data[23:8];
            if (wr_data[23:8] == '0) s_d.pend = 1'b1;
        end
        if (take_pay) begin
            s_d.rem = s_q.rem - WCW'(push_nb);
            if (s_q.rem <= WCW'(4)) s_d.pend = 1'b1;
        end
        if (take_sht) s_d.pend = 1'b1;

        if (push)
            s_d.wr_off = ((AW+1)'(s_q.wr_off) + 1'b1 == s_q.size) ? '0 : s_q.wr_off + 1'b1;
        if (pop)
            s_d.rd_off = ((AW+1)'(s_q.rd_off) + 1'b1 == s_q.size) ? '0 : s_q.rd_off + 1'b1;

        s_d.cnt = s_q.cnt + (AW+1)'(push) - (AW+1)'(pop);
        if (s_d.cnt == '0) begin
            s_d.send = 1'b0;
            s_d.pend = 1'b0;
        end else if (trig && s_q.cnt != '0) begin
            s_d.send = 1'b1;
        end

        push_addr = s_q.base + s_q.wr_off;
        rd_addr   = s_q.base + s_q.rd_off;
        has_data  = s_q.send;
        active    = s_q.active;
        dma_req   = s_q.active && en && (s_q.rem != '0) && (free_w >= thr_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.size);
    a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> (s_q.cnt == '0));
    a_r8_send_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.send |-> (s_q.cnt != '0));
endmodule

// File: rtl/txf_arb.sv
module txf_arb #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] has_data,
    input  logic [2:0]     cur_nb,
    input  logic           out_ready,
    output logic [CHW-1:0] sel,
    output logic [1:0]     byte_idx,
    output logic           valid,
    output logic [NCH-1:0] pop
);
    typedef struct packed {
        logic           lock;
        logic [CHW-1:0] cur;
        logic [1:0]     idx;
    } arb_s;

    arb_s a_q, a_d;
    logic [CHW-1:0] pick;
    logic last;

    always_comb begin
        a_d  = a_q;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (has_data[i]) pick = CHW'(i);
        sel      = a_q.lock ? a_q.cur : pick;
        valid    = has_data[sel];
        byte_idx = a_q.idx;
        last     = ({1'b0, a_q.idx} == cur_nb - 3'd1);
        pop      = '0;
        if (valid) begin
            a_d.cur  = sel;
            a_d.lock = 1'b1;
            if (out_ready) begin
                if (last) begin
                    pop[sel] = 1'b1;
                    a_d.idx  = '0;
                    a_d.lock = 1'b0;
                end else begin
                    a_d.idx = a_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    a_r7_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
endmodule

// File: rtl/dsl_cmd_txfifo.sv
module dsl_cmd_txfifo #(
    parameter int NCH   = 2,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CHW  = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      ch_en,
    input  logic [NCH*AW-1:0]   cfg_base,
    input  logic [NCH*(AW+1)-1:0] cfg_size,
    input  logic [2:0]          thr_sel,
    input  logic                wr_en,
    input  logic [CHW-1:0]      wr_ch,
    input  logic [1:0]          wr_kind,
    input  logic [31:0]         wr_data,
    output logic [NCH-1:0]      ch_active,
    output logic [NCH-1:0]      dma_req,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [7:0]          out_data,
    output logic                out_short,
    output logic [CHW-1:0]      out_ch
);
    import txf_pkg::*;

    txf_entry_t     mem_q [DEPTH];
    txf_entry_t     rd_word, wr_word;
    logic [NCH-1:0] push_v, has_v, pop_v;
    logic [AW-1:0]  paddr_v [NCH];
    logic [AW-1:0]  rd_v [NCH];
    logic [2:0]     pnb_v [NCH];
    logic [AW-1:0]  push_addr;
    logic [CHW-1:0] sel;
    logic [1:0]     byte_idx;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CHW'(c));
        txf_chan #(.AW(AW), .WCW(16)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[c]),
            .cfg_base  (cfg_base[c*AW +: AW]),
            .cfg_size  (cfg_size[c*(AW+1) +: AW+1]),
            .thr_words ({1'b0, thr_sel} + 4'd1),
            .wr_hdr    (hit && wr_kind == WK_HDR),
            .wr_pay    (hit && wr_kind == WK_PAY),
            .wr_sht    (hit && wr_kind == WK_SHT),
            .wr_data   (wr_data),
            .pop       (pop_v[c]),
            .push      (push_v[c]),
            .push_addr (paddr_v[c]),
            .push_nb   (pnb_v[c]),
            .rd_addr   (rd_v[c]),
            .has_data  (has_v[c]),
            .active    (ch_active[c]),
            .dma_req   (dma_req[c])
        );
    end

    always_comb begin
        push_addr        = '0;
        wr_word.data     = wr_data;
        wr_word.is_short = (wr_kind == WK_SHT);
        wr_word.nb       = 3'd4;
        for (int i = 0; i < NCH; i++)
            if (push_v[i]) begin
                push_addr  = paddr_v[i];
                wr_word.nb = pnb_v[i];
            end
    end

    always_ff @(posedge clk) begin
        if (|push_v) mem_q[push_addr] <= wr_word;
    end

    assign rd_word = mem_q[rd_v[sel]];

    txf_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .has_data  (has_v),
        .cur_nb    (rd_word.nb),
        .out_ready (out_ready),
        .sel       (sel),
        .byte_idx  (byte_idx),
        .valid     (out_valid),
        .pop       (pop_v)
    );

    assign out_data  = rd_word.data[8*byte_idx +: 8];
    assign out_short = rd_word.is_short;
    assign out_ch    = sel;

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_short) && $stable(out_ch)));
endmodule

// File: tb/dsl_cmd_txfifo_test.sv
module dsl_cmd_txfifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ch_en = 2'b00;
    logic [7:0]  cfg_base = {4'd8, 4'd0};
    logic [9:0]  cfg_size = {5'd8, 5'd8};
    logic [2:0]  thr_sel = 3'd3;
    logic        wr_en = 1'b0;
    logic        wr_ch = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ch_active, dma_req;
    logic        out_valid, out_ready = 1'b0, out_short, out_ch;
    logic [7:0]  out_data;
    int checks = 0, errors = 0;
    bit done = 0;
    logic [9:0] capq [$];

    always #5 clk = ~clk;

    dsl_cmd_txfifo uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .thr_sel(thr_sel), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_kind(wr_kind), .wr_data(wr_data), .ch_active(ch_active),
        .dma_req(dma_req), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_short(out_short), .out_ch(out_ch)
    );

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) capq.push_back({out_ch, out_short, out_data});

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic ch, input logic [1:0] kind, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_ch = ch; wr_kind = kind; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_word(input string req, input logic ch, input logic sh,
                               input logic [31:0] w, input int n);
        for (int b = 0; b < n; b++) begin
            logic [9:0] v;
            v = (capq.size() != 0) ? capq.pop_front() : 10'h3ff;
            chk(req, 32'(v), 32'({ch, sh, w[8*b +: 8]}));
        end
    endtask

    task automatic recycle(input int c);
        ch_en[c] = 1'b0; tick(3);
        chk("R11 inactive after drain", 32'(ch_active[c]), 32'd0);
        ch_en[c] = 1'b1; tick(2);
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 dma_req", 32'(dma_req), 32'd0);
        chk("R1 ch_active", 32'(ch_active), 32'd0);
    endtask

    task automatic t_enable;
        ch_en = 2'b01; tick(1);
        chk("R2 ch_active", 32'(ch_active), 32'd1);
        wr(1'b1, 2'd2, 32'h55555555); tick(5);
        chk("R2 write to disabled channel ignored", 32'(out_valid), 32'd0);
    endtask

    task automatic t_long;
        capq.delete(); out_ready = 1'b1;
        wr(1'b0, 2'd0, {8'h00, 16'd6, 8'h29});
        wr(1'b0, 2'd1, 32'h44332211); tick(3);
        chk("R8 no start before complete", 32'(out_valid), 32'd0);
        chk("R8 no bytes yet", 32'(capq.size()), 32'd0);
        wr(1'b0, 2'd1, 32'h88776655);
        wr(1'b0, 2'd1, 32'hDEADBEEF); tick(20);
        expect_word("R3 header bytes", 1'b0, 1'b0, {8'h00, 16'd6, 8'h29}, 4);
        expect_word("R7 payload order", 1'b0, 1'b0, 32'h44332211, 4);
        expect_word("R4 trimmed last word", 1'b0, 1'b0, 32'h88776655, 2);
        chk("R5 surplus payload dropped", 32'(capq.size()), 32'd0);
    endtask

    task automatic t_zero_wc;
        capq.delete();
        wr(1'b0, 2'd0, {8'h00, 16'd0, 8'h09}); tick(10);
        expect_word("R3 zero count header", 1'b0, 1'b0, 32'h00000009, 4);
        chk("R3 nothing extra", 32'(capq.size()), 32'd0);
    endtask

    task automatic t_short;
        capq.delete();
        wr(1'b0, 2'd2, 32'hDDCCBBAA); tick(10);
        expect_word("R6 short packet", 1'b0, 1'b1, 32'hDDCCBBAA, 4);
    endtask

    task automatic t_burst;
        logic [7:0] d0;
        capq.delete(); out_ready = 1'b0; thr_sel = 3'd3;
        wr(1'b0, 2'd0, {8'h00, 16'd40, 8'h39});
        chk("R12 request raised", 32'(dma_req[0]), 32'd1);
        for (int k = 0; k < 3; k++) wr(1'b0, 2'd1, 32'h01010101 * (k + 1));
        tick(2);
        chk("R10 no early start", 32'(out_valid), 32'd0);
        chk("R12 request with room", 32'(dma_req[0]), 32'd1);
        wr(1'b0, 2'd1, 32'h04040404);
        chk("R12 request drops", 32'(dma_req[0]), 32'd0);
        tick(2);
        chk("R10 start on low space", 32'(out_valid), 32'd1);
        d0 = out_data; tick(3);
        chk("R13 held valid", 32'(out_valid), 32'd1);
        chk("R13 held data", 32'(out_data), 32'(d0));
        chk("R13 first byte", 32'(out_data), 32'h39);
        out_ready = 1'b1; tick(40);
        expect_word("R10 header", 1'b0, 1'b0, {8'h00, 16'd40, 8'h39}, 4);
        for (int k = 0; k < 4; k++)
            expect_word("R7 burst order", 1'b0, 1'b0, 32'h01010101 * (k + 1), 4);
        recycle(0);
    endtask

    task automatic t_full;
        capq.delete(); out_ready = 1'b0; thr_sel = 3'd0;
        wr(1'b0, 2'd0, {8'h00, 16'd100, 8'h19});
        for (int k = 0; k < 6; k++) wr(1'b0, 2'd1, 32'h10101010 * (k + 1));
        tick(2);
        chk("R9 no start with one free", 32'(out_valid), 32'd0);
        wr(1'b0, 2'd1, 32'h70707070); tick(2);
        chk("R9 start when full", 32'(out_valid), 32'd1);
        wr(1'b0, 2'd1, 32'hEEEEEEEE);
        out_ready = 1'b1; tick(50);
        expect_word("R9 header", 1'b0, 1'b0, {8'h00, 16'd100, 8'h19}, 4);
        for (int k = 0; k < 7; k++)
            expect_word("R9 payload", 1'b0, 1'b0, 32'h10101010 * (k + 1), 4);
        chk("R9 write to full region dropped", 32'(capq.size()), 32'd0);
        thr_sel = 3'd3;
        recycle(0);
    endtask

    task automatic t_flush;
        capq.delete(); out_ready = 1'b1;
        ch_en = 2'b11; tick(2);
        chk("R2 second channel active", 32'(ch_active), 32'd3);
        wr(1'b1, 2'd0, {8'h00, 16'd20, 8'h2A});
        wr(1'b1, 2'd1, 32'h0D0C0B0A); tick(3);
        chk("R11 held before disable", 32'(out_valid), 32'd0);
        ch_en[1] = 1'b0; tick(1);
        chk("R11 active while flushing", 32'(ch_active[1]), 32'd1);
        tick(20);
        chk("R11 inactive after flush", 32'(ch_active[1]), 32'd0);
        expect_word("R14 flushed header ch1", 1'b1, 1'b0, {8'h00, 16'd20, 8'h2A}, 4);
        expect_word("R14 flushed payload ch1", 1'b1, 1'b0, 32'h0D0C0B0A, 4);
    endtask

    task automatic t_sep;
        capq.delete(); out_ready = 1'b0;
        ch_en = 2'b11; tick(2);
        wr(1'b0, 2'd2, 32'h03020100);
        wr(1'b1, 2'd2, 32'h13121110);
        wr(1'b0, 2'd2, 32'h07060504);
        out_ready = 1'b1; tick(40);
        expect_word("R14 ch0 first", 1'b0, 1'b1, 32'h03020100, 4);
        expect_word("R14 ch0 wins boundary", 1'b0, 1'b1, 32'h07060504, 4);
        expect_word("R14 ch1 after", 1'b1, 1'b1, 32'h13121110, 4);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1; tick(2);
        t_reset();
        t_enable();
        t_long();
        t_zero_wc();
        t_short();
        t_burst();
        t_full();
        t_flush();
        t_sep();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule